// File: doc/BRIEF.md
# VLAN Egress Tag-Strip Flag Table

This block holds one "remove the VLAN tag on transmit" flag for every one of the 4096 VLAN identifiers. The flags are kept as 256 words of 16 flags each. A host changes them one whole word at a time, through a single configuration write. That write carries both the word number and the new 16-flag value.

On the egress path, the frame's 12-bit VLAN ID is presented on a lookup port together with a valid strobe. One clock later the block returns the matching flag with its own valid strobe. A flag of 1 tells the tag-removal logic to strip the tag. A flag of 0 tells it to keep the tag.

Word numbers of 256 and above belong to other buffers that share the configuration register, so this table ignores them. Reset clears every flag, so no tag is stripped until software programs the table.

Top module: `vlan_untag_table`

## Requirements
- R1: While reset is held and after reset ends, every flag reads 0 and `res_valid` is 0 until a lookup is made.
- R2: A write with `cfg_we` high takes its word number from `cfg_wdata[9:0]` and its flag word from `cfg_wdata[25:10]`. When the word number is below 256, the whole stored 16-bit word is replaced by the flag word.
- R3: A write whose word number is 256 or more (any of `cfg_wdata[9:8]` set) changes no flag.
- R4: A lookup of VID v reads word v[11:4] at bit v[3:0]. Bit n of the flag word written to word w therefore belongs to VID w*16+n. A returned 1 means strip the tag and 0 means keep it.
- R5: `res_valid` is high exactly one cycle after each cycle in which `lk_valid` is high, and `res_untag` carries that lookup's flag in the same cycle. Lookups may be made on back-to-back cycles.
- R6: A lookup made in the same cycle as a write to the same word returns the flag as it was before the write. A lookup in the next cycle sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 26 | Word number [9:0] and flag word [25:10] |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vid | input | 12 | VLAN ID to look up |
| res_valid | output | 1 | Lookup result strobe, one cycle after the request |
| res_untag | output | 1 | 1 = strip the tag, 0 = keep it |

## Verification
Several rules are checked by the assertions on every cycle:
- the one-cycle result timing;
- whole-word replacement of a legal write;
- the immunity of the table to writes with reserved word numbers;
- the old-value result when a write and a lookup meet on the same word;
- the all-zero table after reset.

The bench scenarios are needed to show the bit ordering inside a word and the corner words 0 and 255. They also show that a reserved word number whose low bits alias a legal word leaves that word untouched, and that a rewrite clears flags that an earlier write had set.

// File: rtl/vut_pkg.sv
package vut_pkg;
  localparam int DEF_VID_W       = 12;
  localparam int DEF_FLAG_W      = 16;
  localparam int DEF_IDX_FIELD_W = 10;
endpackage

// File: rtl/vut_rst_sync.sv
module vut_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/vut_wr_decode.sv
module vut_wr_decode #(
  parameter int IDX_FIELD_W = 10,
  parameter int FLAG_W      = 16,
  parameter int WIDX_W      = 8,
  localparam int CFG_W      = IDX_FIELD_W + FLAG_W
) (
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              wr_en,
  output logic [WIDX_W-1:0] wr_word,
  output logic [FLAG_W-1:0] wr_mask
);
  logic reserved;

  generate
    if (IDX_FIELD_W > WIDX_W) begin : g_resv
      assign reserved = |cfg_wdata[IDX_FIELD_W-1:WIDX_W];
    end else begin : g_nores
      assign reserved = 1'b0;
    end
  endgenerate

  always_comb begin
    wr_en   = cfg_we && !reserved;
    wr_word = cfg_wdata[WIDX_W-1:0];
    wr_mask = cfg_wdata[CFG_W-1:IDX_FIELD_W];
  end
endmodule

// File: rtl/vut_bitmap_store.sv
module vut_bitmap_store #(
  parameter int FLAG_W = 16,
  parameter int WIDX_W = 8,
  localparam int WORDS = 2 ** WIDX_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [WIDX_W-1:0]             wr_word,
  input  logic [FLAG_W-1:0]             wr_mask,
  output logic [WORDS-1:0][FLAG_W-1:0]  tbl
);
  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic              word_ce;
      logic [FLAG_W-1:0] word_d;
      logic [FLAG_W-1:0] word_q;

      always_comb begin
        word_ce = wr_en && (wr_word == WIDX_W'(w));
        word_d  = word_ce ? wr_mask : word_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
      end

      assign tbl[w] = word_q;
    end
  endgenerate
endmodule

// File: rtl/vut_lookup.sv
module vut_lookup #(
  parameter int VID_W  = 12,
  parameter int FLAG_W = 16,
  localparam int BIT_W  = $clog2(FLAG_W),
  localparam int WIDX_W = VID_W - BIT_W,
  localparam int WORDS  = 2 ** WIDX_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lk_valid,
  input  logic [VID_W-1:0]              lk_vid,
  input  logic [WORDS-1:0][FLAG_W-1:0]  tbl,
  output logic                          res_valid,
  output logic                          res_untag
);
  logic [WIDX_W-1:0] sel_word;
  logic [BIT_W-1:0]  sel_bit;
  logic              valid_d;
  logic              untag_d;

  always_comb begin
    sel_word = lk_vid[VID_W-1:BIT_W];
    sel_bit  = lk_vid[BIT_W-1:0];
    valid_d  = lk_valid;
    untag_d  = lk_valid ? tbl[sel_word][sel_bit] : res_untag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_untag <= 1'b0;
    end else begin
      res_valid <= valid_d;
      res_untag <= untag_d;
    end
  end
endmodule

// File: rtl/vlan_untag_table.sv
module vlan_untag_table #(
  parameter int VID_W       = vut_pkg::DEF_VID_W,
  parameter int FLAG_W      = vut_pkg::DEF_FLAG_W,
  parameter int IDX_FIELD_W = vut_pkg::DEF_IDX_FIELD_W,
  localparam int BIT_W      = $clog2(FLAG_W),
  localparam int WIDX_W     = VID_W - BIT_W,
  localparam int WORDS      = 2 ** WIDX_W,
  localparam int CFG_W      = IDX_FIELD_W + FLAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             lk_valid,
  input  logic [VID_W-1:0] lk_vid,
  output logic             res_valid,
  output logic             res_untag
);
  logic                         rst_sync_n;
  logic                         wr_en;
  logic [WIDX_W-1:0]            wr_word;
  logic [FLAG_W-1:0]            wr_mask;
  logic [WORDS-1:0][FLAG_W-1:0] tbl;

  vut_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  vut_wr_decode #(.IDX_FIELD_W(IDX_FIELD_W), .FLAG_W(FLAG_W), .WIDX_W(WIDX_W)) u_dec (
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .wr_en(wr_en), .wr_word(wr_word), .wr_mask(wr_mask)
  );

  vut_bitmap_store #(.FLAG_W(FLAG_W), .WIDX_W(WIDX_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_word(wr_word),
    .wr_mask(wr_mask), .tbl(tbl)
  );

  vut_lookup #(.VID_W(VID_W), .FLAG_W(FLAG_W)) u_look (
    .clk(clk), .rst_n(rst_sync_n), .lk_valid(lk_valid), .lk_vid(lk_vid),
    .tbl(tbl), .res_valid(res_valid), .res_untag(res_untag)
  );
endmodule

// File: rtl/vut_checker.sv
module vut_checker #(
  parameter int VID_W       = 12,
  parameter int FLAG_W      = 16,
  parameter int IDX_FIELD_W = 10,
  localparam int BIT_W      = $clog2(FLAG_W),
  localparam int WIDX_W     = VID_W - BIT_W,
  localparam int WORDS      = 2 ** WIDX_W,
  localparam int CFG_W      = IDX_FIELD_W + FLAG_W
) (
  input logic                         clk,
  input logic                         rst_sync_n,
  input logic                         cfg_we,
  input logic [CFG_W-1:0]             cfg_wdata,
  input logic                         lk_valid,
  input logic [VID_W-1:0]             lk_vid,
  input logic [WORDS-1:0][FLAG_W-1:0] tbl,
  input logic                         res_valid,
  input logic                         res_untag
);
  logic              legal_wr;
  logic [WIDX_W-1:0] w_idx;
  logic [FLAG_W-1:0] w_mask;
  logic [WIDX_W-1:0] l_word;
  logic [BIT_W-1:0]  l_bit;
  logic              old_bit;
  logic              wr_q;
  logic [WIDX_W-1:0] idx_q;
  logic [FLAG_W-1:0] mask_q;

  always_comb begin
    legal_wr = cfg_we && (cfg_wdata[IDX_FIELD_W-1:WIDX_W] == '0);
    w_idx    = cfg_wdata[WIDX_W-1:0];
    w_mask   = cfg_wdata[CFG_W-1:IDX_FIELD_W];
    l_word   = lk_vid[VID_W-1:BIT_W];
    l_bit    = lk_vid[BIT_W-1:0];
    old_bit  = tbl[l_word][l_bit];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_q   <= 1'b0;
      idx_q  <= '0;
      mask_q <= '0;
    end else begin
      wr_q   <= legal_wr;
      idx_q  <= w_idx;
      mask_q <= w_mask;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> (tbl == '0 && !res_valid));

  // R2
  whole_word_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_q |-> tbl[idx_q] == mask_q);

  // R3
  reserved_ignore_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && !legal_wr) |=> $stable(tbl));

  // R4
  fresh_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lk_valid && !legal_wr && wr_q && l_word == idx_q) |=> res_untag == $past(mask_q[l_bit]));

  // R5
  result_valid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_valid |=> res_valid);

  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !lk_valid |=> !res_valid);

  // R6
  collide_old_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lk_valid && legal_wr && w_idx == l_word) |=> res_untag == $past(old_bit));
endmodule

bind vlan_untag_table vut_checker #(
  .VID_W(VID_W), .FLAG_W(FLAG_W), .IDX_FIELD_W(IDX_FIELD_W)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .lk_valid(lk_valid), .lk_vid(lk_vid), .tbl(tbl),
  .res_valid(res_valid), .res_untag(res_untag)
);

// File: tb/vlan_untag_table_bench.sv
`timescale 1ns/1ps
module vlan_untag_table_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [25:0] cfg_wdata = '0;
  logic        lk_valid = 1'b0;
  logic [11:0] lk_vid = '0;
  logic        res_valid;
  logic        res_untag;

  typedef struct {
    bit    exp;
    int    due;
    string tag;
  } item_t;

  item_t       sb[$];
  logic [15:0] model [256];
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          mon_en = 1'b0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vlan_untag_table u_vlan_untag_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .lk_valid(lk_valid), .lk_vid(lk_vid),
    .res_valid(res_valid), .res_untag(res_untag)
  );

  function automatic logic [25:0] mk(input logic [9:0] idx, input logic [15:0] m);
    return {m, idx};
  endfunction

  task automatic step(input bit we, input logic [25:0] wd, input bit lv,
                      input logic [11:0] vid, input string tag);
    item_t it;
    @(negedge clk);
    cfg_we    = we;
    cfg_wdata = wd;
    lk_valid  = lv;
    lk_vid    = vid;
    if (lv) begin
      it.exp = model[vid[11:4]][vid[3:0]];
      it.due = cyc + 1;
      it.tag = tag;
      sb.push_back(it);
    end
    if (we && wd[9:8] == 2'b00) model[wd[7:0]] = wd[25:10];
  endtask

  task automatic look(input logic [11:0] vid, input string tag);
    step(1'b0, '0, 1'b1, vid, tag);
  endtask

  task automatic wr(input logic [9:0] idx, input logic [15:0] m, input string tag);
    step(1'b1, mk(idx, m), 1'b0, '0, tag);
  endtask

  // monitor: compares results against the scoreboard queue
  always @(negedge clk) begin
    if (mon_en) begin
      if (res_valid) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 unexpected result: res_valid=1 expected 0");
        end else begin
          item_t it;
          it = sb.pop_front();
          checks++;
          if (res_untag !== it.exp || cyc != it.due) begin
            errors++;
            $display("FAIL %s untag=%0b at cycle %0d, expected %0b at cycle %0d",
                     it.tag, res_untag, cyc, it.exp, it.due);
          end
        end
      end else if (sb.size() > 0 && sb[0].due <= cyc) begin
        checks++; errors++;
        $display("FAIL R5 missing result: res_valid=0 expected 1 (%s)", sb[0].tag);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 res_valid in reset=%0b expected 0", res_valid);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 res_valid after reset=%0b expected 0", res_valid);
    end
    mon_en = 1'b1;

    // R1: cleared table
    look(12'h000, "R1");
    look(12'hFFF, "R1");
    look(12'h4D2, "R1");

    // R2 R4: bit order inside word 5, back-to-back lookups (R5)
    wr(10'd5, 16'hA5A5, "R2");
    for (int b = 0; b < 16; b++) look(12'h050 + 12'(b), "R4");

    // R4: corner words
    wr(10'd255, 16'h8001, "R2");
    wr(10'd0, 16'h0002, "R2");
    look(12'hFFF, "R4");
    look(12'hFF0, "R4");
    look(12'hFF1, "R4");
    look(12'h001, "R4");
    look(12'h000, "R4");

    // R3: reserved word numbers whose low bits alias words 5 and 255
    wr(10'h105, 16'hFFFF, "R3");
    wr(10'h3FF, 16'hFFFF, "R3");
    look(12'h051, "R3");
    look(12'h053, "R3");
    look(12'hFFE, "R3");
    look(12'hFF8, "R3");

    // R2: rewrite replaces the whole word
    wr(10'd5, 16'h0001, "R2");
    look(12'h057, "R2");
    look(12'h05F, "R2");
    look(12'h050, "R2");

    // R6: same-cycle collision returns old value, then new
    step(1'b1, mk(10'd5, 16'hFFFF), 1'b1, 12'h057, "R6");
    look(12'h057, "R6");
    step(1'b1, mk(10'd9, 16'h0010), 1'b1, 12'h094, "R6");
    look(12'h094, "R6");

    // R5: gapped lookups
    step(1'b0, '0, 1'b0, '0, "R5");
    look(12'h05A, "R5");
    step(1'b0, '0, 1'b0, '0, "R5");
    step(1'b0, '0, 1'b0, '0, "R5");
    look(12'h093, "R5");
    step(1'b0, '0, 1'b0, '0, "R5");
    repeat (3) @(negedge clk);

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R5 pending results=%0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule